// File: doc/BRIEF.md
# Debug Bus Access Match Comparator

This block sits beside a CPU bus and watches every access. Four comparators are each loaded with an address, and two of them also hold a data value with a per-bit mask. When an access fits a comparator's criteria the block emits a trigger pulse, along with a vector that tells which comparators fired. A comparator can also be set to tag mode. In that mode an opcode fetch from its address is only remembered. The trigger fires later, and only if the execute-stage strobe reports that address. A pipeline flush discards every remembered tag.

Software reaches the comparators through an eight-byte register window, and a 2-bit bank select picks which comparator shows in it. A comparator with its break bit set can raise a break request, provided the global break enable is high. When a break request is raised, every comparator is disarmed and every pending tag is dropped. The bus side is a passive monitor, so it has no back-pressure. An access is observed in each cycle where `bus_valid` is high, and the block can never stall the bus.

Top module: `bus_match_unit`

## Requirements
- R1: After reset every window byte reads 0, every comparator is disarmed (control bit 0 = arm), `trig_o`, `trig_src_o` and `brk_o` are 0, and an unarmed comparator never fires.
- R2: Bank select `win_sel` = n shows comparator n. Offset 0 is control, offsets 1..3 are address bits [23:16], [15:8] and [7:0], offsets 4/5 are data high/low, and offsets 6/7 are mask high/low. Only banks 0 and 2 have data and mask. On banks 1 and 3, offsets 4..7 read 0 and writes to them have no effect.
- R3: An armed comparator in trigger mode (control bit 5 = 0) fires only when the full 24-bit address is equal. `trig_o` is high in the cycle after the observed access.
- R4: On banks 0 and 2 with control bit 6 = 0, every data bit whose mask bit is 1 must equal the stored data. A word access compares both bytes. A byte access compares only the high byte when address bit 0 is 0, and only the low byte when it is 1.
- R5: With control bit 6 = 1 on banks 0/2, the comparator fires only if at least one unmasked compared bit differs. If all compared bits are masked, it never fires.
- R6: On banks 1 and 3 with control bit 7 = 1, the access size must equal control bit 6 (0 = word, 1 = byte). With bit 7 = 0, size is not checked.
- R7: With control bit 2 = 1, the direction must equal control bit 3 (0 = write, 1 = read). With bit 2 = 0, direction is not checked.
- R8: In tag mode (control bit 5 = 1), a fetch from the address stores a tag and fires nothing. Data, size and direction qualifiers are ignored. Each execute strobe with a tagged address fires one tag, and `trig_o` is high in the next cycle.
- R9: At most four tags are pending, and further tags are dropped. `flush` clears all tags and suppresses any tag trigger in that cycle.
- R10: When a firing comparator has control bit 4 = 1 and `brk_en` is 1, `brk_o` pulses together with `trig_o`, and all arm bits are cleared by the same edge. With `brk_en` = 0 there is no break and no disarm.
- R11: `trig_src_o` bit n is 1 exactly when comparator n contributed to the trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| win_sel | input | 2 | Comparator bank shown in the window |
| reg_wr | input | 1 | Window write strobe |
| reg_addr | input | 3 | Window byte offset |
| reg_wdata | input | 8 | Window write data |
| reg_rdata | output | 8 | Window read data (combinational) |
| bus_valid | input | 1 | Bus access observed this cycle |
| bus_addr | input | 24 | Access address |
| bus_data | input | 16 | Access data, high byte on bits 15:8 |
| bus_byte | input | 1 | 1 = byte access, 0 = word |
| bus_read | input | 1 | 1 = read, 0 = write |
| bus_fetch | input | 1 | Access is an opcode fetch |
| exec_valid | input | 1 | An opcode reaches execution |
| exec_addr | input | 24 | Address of the executing opcode |
| flush | input | 1 | Pipeline flush, drops tags |
| brk_en | input | 1 | Global break enable |
| trig_o | output | 1 | Trigger pulse |
| trig_src_o | output | 4 | Comparators behind the trigger |
| brk_o | output | 1 | Break request pulse |

## Verification
A bus access that is observed at a clock edge shows on `trig_o`, `trig_src_o` and `brk_o` one cycle later. A tagged opcode produces no result at its fetch. Its result comes one cycle after the execute strobe. Window writes land at the edge and are read back combinationally. The bench drives every stimulus on a falling edge and reads the results on the next falling edge, which is exactly one register stage later. A flush or a tag-capacity check is followed by an execute strobe whose one-cycle response is sampled the same way.

// File: rtl/bmu_pkg.sv
package bmu_pkg;
  localparam int ADDR_W  = 24;
  localparam int DATA_W  = 16;
  localparam int WIN_LEN = 8;

  // control byte bit positions
  localparam int CB_ARM = 0;
  localparam int CB_RWE = 2;
  localparam int CB_RW  = 3;
  localparam int CB_BRK = 4;
  localparam int CB_TAG = 5;
  localparam int CB_ALT = 6;  // data invert (data banks) or size value (size banks)
  localparam int CB_SZE = 7;

  typedef struct packed {
    logic [7:0]        ctrl;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
    logic [DATA_W-1:0] mask;
  } cmp_cfg_t;
endpackage

// File: rtl/bmu_regbank.sv
module bmu_regbank
  import bmu_pkg::*;
#(
  parameter int NUM_CMP = 4,
  localparam int SEL_W  = $clog2(NUM_CMP)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr,
  input  logic [SEL_W-1:0]           sel,
  input  logic [2:0]                 waddr,
  input  logic [7:0]                 wdata,
  input  logic                       disarm,
  output cmp_cfg_t [NUM_CMP-1:0]     cfg_o,
  output logic [7:0]                 rdata
);
  logic [7:0] view [NUM_CMP][WIN_LEN];

  for (genvar i = 0; i < NUM_CMP; i++) begin : g_bank
    localparam bit HAS_DATA = (i % 2) == 0;
    logic hit_wr;
    assign hit_wr = wr && (sel == SEL_W'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cfg_o[i] <= '0;
      end else begin
        if (hit_wr) begin
          case (waddr)
            3'd0: cfg_o[i].ctrl         <= wdata;
            3'd1: cfg_o[i].addr[23:16]  <= wdata;
            3'd2: cfg_o[i].addr[15:8]   <= wdata;
            3'd3: cfg_o[i].addr[7:0]    <= wdata;
            3'd4: if (HAS_DATA) cfg_o[i].data[15:8] <= wdata;
            3'd5: if (HAS_DATA) cfg_o[i].data[7:0]  <= wdata;
            3'd6: if (HAS_DATA) cfg_o[i].mask[15:8] <= wdata;
            default: if (HAS_DATA) cfg_o[i].mask[7:0] <= wdata;
          endcase
        end
        if (disarm) cfg_o[i].ctrl[CB_ARM] <= 1'b0;
      end
    end

    always_comb begin
      view[i][0] = cfg_o[i].ctrl;
      view[i][1] = cfg_o[i].addr[23:16];
      view[i][2] = cfg_o[i].addr[15:8];
      view[i][3] = cfg_o[i].addr[7:0];
      view[i][4] = HAS_DATA ? cfg_o[i].data[15:8] : 8'h00;
      view[i][5] = HAS_DATA ? cfg_o[i].data[7:0]  : 8'h00;
      view[i][6] = HAS_DATA ? cfg_o[i].mask[15:8] : 8'h00;
      view[i][7] = HAS_DATA ? cfg_o[i].mask[7:0]  : 8'h00;
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_CMP; i++)
      if (sel == SEL_W'(i)) rdata = view[i][waddr];
  end
endmodule

// File: rtl/bmu_cmp.sv
module bmu_cmp
  import bmu_pkg::*;
#(
  parameter bit HAS_DATA = 1'b1
) (
  input  cmp_cfg_t          cfg,
  input  logic              bus_valid,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_data,
  input  logic              bus_byte,
  input  logic              bus_read,
  input  logic              bus_fetch,
  output logic              imm_hit,
  output logic              tag_hit
);
  logic armed, tag_mode, addr_eq, rw_ok, size_ok, data_ok;
  logic lane_hi, lane_lo;
  logic [DATA_W-1:0] lanes, diff;

  assign armed    = cfg.ctrl[CB_ARM];
  assign tag_mode = cfg.ctrl[CB_TAG];
  assign addr_eq  = bus_addr == cfg.addr;
  assign rw_ok    = !cfg.ctrl[CB_RWE] || (cfg.ctrl[CB_RW] == bus_read);

  assign lane_hi = !bus_byte || !bus_addr[0];
  assign lane_lo = !bus_byte ||  bus_addr[0];
  assign lanes   = {{8{lane_hi}}, {8{lane_lo}}};
  assign diff    = (bus_data ^ cfg.data) & cfg.mask & lanes;

  if (HAS_DATA) begin : g_data
    assign data_ok = cfg.ctrl[CB_ALT] ? (|diff) : !(|diff);
    assign size_ok = 1'b1;
  end else begin : g_size
    assign data_ok = 1'b1;
    assign size_ok = !cfg.ctrl[CB_SZE] || (cfg.ctrl[CB_ALT] == bus_byte);
  end

  assign imm_hit = bus_valid && armed && !tag_mode && addr_eq && data_ok && size_ok && rw_ok;
  assign tag_hit = bus_valid && armed &&  tag_mode && addr_eq && bus_fetch;
endmodule

// File: rtl/bmu_tagq.sv
module bmu_tagq
  import bmu_pkg::*;
#(
  parameter int DEPTH   = 4,
  parameter int NUM_CMP = 4,
  localparam int IW     = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               push,
  input  logic [ADDR_W-1:0]  push_addr,
  input  logic [NUM_CMP-1:0] push_src,
  input  logic               exec_valid,
  input  logic [ADDR_W-1:0]  exec_addr,
  input  logic               flush,
  input  logic               clear,
  output logic [NUM_CMP-1:0] fire_src,
  output logic [DEPTH-1:0]   vld_o
);
  logic [DEPTH-1:0]   vld;
  logic [ADDR_W-1:0]  addr_q [DEPTH];
  logic [NUM_CMP-1:0] src_q  [DEPTH];
  logic [IW-1:0]      hit_idx, free_idx;
  logic               hit_found, free_found, fire;

  always_comb begin
    hit_idx = '0; hit_found = 1'b0;
    free_idx = '0; free_found = 1'b0;
    for (int k = DEPTH - 1; k >= 0; k--) begin
      if (vld[k] && addr_q[k] == exec_addr) begin
        hit_idx = IW'(k); hit_found = 1'b1;
      end
      if (!vld[k]) begin
        free_idx = IW'(k); free_found = 1'b1;
      end
    end
  end

  assign fire     = exec_valid && hit_found && !flush;
  assign fire_src = fire ? src_q[hit_idx] : '0;
  assign vld_o    = vld;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld <= '0;
      for (int k = 0; k < DEPTH; k++) begin
        addr_q[k] <= '0;
        src_q[k]  <= '0;
      end
    end else if (flush || clear) begin
      vld <= '0;
    end else begin
      if (fire) vld[hit_idx] <= 1'b0;
      if (push && free_found) begin
        vld[free_idx]    <= 1'b1;
        addr_q[free_idx] <= push_addr;
        src_q[free_idx]  <= push_src;
      end
    end
  end
endmodule

// File: rtl/bus_match_unit.sv
module bus_match_unit
  import bmu_pkg::*;
#(
  parameter int NUM_CMP   = 4,
  parameter int TAG_DEPTH = 4,
  localparam int SEL_W    = $clog2(NUM_CMP)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [SEL_W-1:0]   win_sel,
  input  logic               reg_wr,
  input  logic [2:0]         reg_addr,
  input  logic [7:0]         reg_wdata,
  output logic [7:0]         reg_rdata,
  input  logic               bus_valid,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_data,
  input  logic               bus_byte,
  input  logic               bus_read,
  input  logic               bus_fetch,
  input  logic               exec_valid,
  input  logic [ADDR_W-1:0]  exec_addr,
  input  logic               flush,
  input  logic               brk_en,
  output logic               trig_o,
  output logic [NUM_CMP-1:0] trig_src_o,
  output logic               brk_o
);
  cmp_cfg_t [NUM_CMP-1:0] cfg;
  logic [NUM_CMP-1:0] imm_hit, tag_hit, fire_src, src_nxt, brk_bits, arm_vec;
  logic [TAG_DEPTH-1:0] tag_vld;
  logic brk_hit;

  bmu_regbank #(.NUM_CMP(NUM_CMP)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .sel(win_sel), .waddr(reg_addr),
    .wdata(reg_wdata), .disarm(brk_hit), .cfg_o(cfg), .rdata(reg_rdata)
  );

  for (genvar i = 0; i < NUM_CMP; i++) begin : g_cmp
    bmu_cmp #(.HAS_DATA((i % 2) == 0)) u_cmp (
      .cfg(cfg[i]), .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_data(bus_data),
      .bus_byte(bus_byte), .bus_read(bus_read), .bus_fetch(bus_fetch),
      .imm_hit(imm_hit[i]), .tag_hit(tag_hit[i])
    );
    assign brk_bits[i] = cfg[i].ctrl[CB_BRK];
    assign arm_vec[i]  = cfg[i].ctrl[CB_ARM];
  end

  bmu_tagq #(.DEPTH(TAG_DEPTH), .NUM_CMP(NUM_CMP)) u_tags (
    .clk(clk), .rst_n(rst_n), .push(|tag_hit), .push_addr(bus_addr), .push_src(tag_hit),
    .exec_valid(exec_valid), .exec_addr(exec_addr), .flush(flush), .clear(brk_hit),
    .fire_src(fire_src), .vld_o(tag_vld)
  );

  assign src_nxt = imm_hit | fire_src;
  assign brk_hit = brk_en && |(src_nxt & brk_bits);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trig_o     <= 1'b0;
      trig_src_o <= '0;
      brk_o      <= 1'b0;
    end else begin
      trig_o     <= |src_nxt;
      trig_src_o <= src_nxt;
      brk_o      <= brk_hit;
    end
  end
endmodule

// File: rtl/bmu_checker.sv
module bmu_checker #(
  parameter int NUM_CMP   = 4,
  parameter int TAG_DEPTH = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 trig_o,
  input logic                 brk_o,
  input logic                 brk_en,
  input logic                 flush,
  input logic [NUM_CMP-1:0]   arm_vec,
  input logic [TAG_DEPTH-1:0] tag_vld
);
  p_brk_with_trig_r10: assert property (@(posedge clk) disable iff (!rst_n)
    brk_o |-> trig_o);

  p_brk_needs_enable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    brk_o |-> $past(brk_en));

  p_brk_disarms_r10: assert property (@(posedge clk) disable iff (!rst_n)
    brk_o |-> arm_vec == '0);

  p_flush_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> tag_vld == '0);

  p_quiet_unarmed_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_vec == '0 && tag_vld == '0) |=> !trig_o);
endmodule

bind bus_match_unit bmu_checker #(.NUM_CMP(NUM_CMP), .TAG_DEPTH(TAG_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .trig_o(trig_o), .brk_o(brk_o), .brk_en(brk_en),
  .flush(flush), .arm_vec(arm_vec), .tag_vld(tag_vld)
);

// File: tb/bus_match_unit_tb_top.sv
`timescale 1ns/1ps
module bus_match_unit_tb_top;
  logic clk = 1'b0;
  logic rst_n;
  logic [1:0] win_sel;
  logic reg_wr;
  logic [2:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic bus_valid, bus_byte, bus_read, bus_fetch, exec_valid, flush, brk_en;
  logic [23:0] bus_addr, exec_addr;
  logic [15:0] bus_data;
  logic trig_o, brk_o;
  logic [3:0] trig_src_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  bus_match_unit dut_i (
    .clk(clk), .rst_n(rst_n), .win_sel(win_sel), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_valid(bus_valid), .bus_addr(bus_addr),
    .bus_data(bus_data), .bus_byte(bus_byte), .bus_read(bus_read), .bus_fetch(bus_fetch),
    .exec_valid(exec_valid), .exec_addr(exec_addr), .flush(flush), .brk_en(brk_en),
    .trig_o(trig_o), .trig_src_o(trig_src_o), .brk_o(brk_o)
  );

  // {addr, data, byte, read, expected source vector}
  localparam int NV = 12;
  localparam logic [45:0] VECS [NV] = '{
    {24'h001000, 16'h1234, 1'b0, 1'b1, 4'b0001},
    {24'h001000, 16'h1235, 1'b0, 1'b1, 4'b0000},
    {24'h001000, 16'h1277, 1'b1, 1'b0, 4'b0001},
    {24'h001000, 16'h5634, 1'b1, 1'b0, 4'b0000},
    {24'h002000, 16'h0000, 1'b1, 1'b0, 4'b0010},
    {24'h002000, 16'h0000, 1'b0, 1'b0, 4'b0000},
    {24'h003000, 16'h00AC, 1'b0, 1'b1, 4'b0100},
    {24'h003000, 16'h77AB, 1'b0, 1'b1, 4'b0000},
    {24'h003000, 16'h00AC, 1'b0, 1'b0, 4'b0000},
    {24'h004000, 16'h0000, 1'b0, 1'b0, 4'b1000},
    {24'h004000, 16'h0000, 1'b0, 1'b1, 4'b0000},
    {24'h005000, 16'h1234, 1'b0, 1'b1, 4'b0000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] b, input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    win_sel = b; reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] b, input logic [2:0] a, output logic [7:0] d);
    win_sel = b; reg_addr = a;
    #0.1;
    d = reg_rdata;
  endtask

  task automatic set_addr(input logic [1:0] b, input logic [23:0] a);
    wr(b, 3'd1, a[23:16]); wr(b, 3'd2, a[15:8]); wr(b, 3'd3, a[7:0]);
  endtask

  // drive one access for one cycle; results are sampled on the next falling edge
  task automatic acc(input logic [23:0] a, input logic [15:0] d, input logic byt,
                     input logic rdn, input logic fch);
    @(negedge clk);
    bus_valid = 1'b1; bus_addr = a; bus_data = d; bus_byte = byt; bus_read = rdn; bus_fetch = fch;
    @(negedge clk);
    bus_valid = 1'b0; bus_fetch = 1'b0;
  endtask

  task automatic ex(input logic [23:0] a, input logic fl);
    @(negedge clk);
    exec_valid = 1'b1; exec_addr = a; flush = fl;
    @(negedge clk);
    exec_valid = 1'b0; flush = 1'b0;
  endtask

  initial begin
    #(5.0 * 20000);
    errors++;
    $display("FAIL watchdog: actual=hung expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] r;
    rst_n = 1'b0; win_sel = 0; reg_wr = 0; reg_addr = 0; reg_wdata = 0;
    bus_valid = 0; bus_addr = 0; bus_data = 0; bus_byte = 0; bus_read = 0; bus_fetch = 0;
    exec_valid = 0; exec_addr = 0; flush = 0; brk_en = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state, unarmed comparators stay silent at address 0
    chk("R1 trig", trig_o, 0);
    chk("R1 brk", brk_o, 0);
    rd(2'd0, 3'd0, r); chk("R1 ctrl0", r, 0);
    rd(2'd3, 3'd3, r); chk("R1 addr3", r, 0);
    acc(24'h0, 16'h0, 1'b0, 1'b1, 1'b0);
    chk("R1 unarmed", trig_o, 0);

    // R2: window banking
    wr(2'd1, 3'd4, 8'h55);
    rd(2'd1, 3'd4, r); chk("R2 no-data bank", r, 0);
    wr(2'd0, 3'd6, 8'hFF);
    rd(2'd0, 3'd6, r); chk("R2 data bank mask", r, 8'hFF);

    // configure for the table
    set_addr(2'd0, 24'h001000);
    wr(2'd0, 3'd4, 8'h12); wr(2'd0, 3'd5, 8'h34); wr(2'd0, 3'd7, 8'hFF);
    wr(2'd0, 3'd0, 8'h01);
    set_addr(2'd1, 24'h002000);
    wr(2'd1, 3'd0, 8'hC1);                 // size check on, byte, armed
    set_addr(2'd2, 24'h003000);
    wr(2'd2, 3'd4, 8'h00); wr(2'd2, 3'd5, 8'hAB);
    wr(2'd2, 3'd6, 8'h00); wr(2'd2, 3'd7, 8'hFF);
    wr(2'd2, 3'd0, 8'h4D);                 // invert, rw check on, read, armed
    set_addr(2'd3, 24'h004000);
    wr(2'd3, 3'd0, 8'h05);                 // rw check on, write, armed
    rd(2'd3, 3'd2, r); chk("R2 addr mid", r, 8'h40);

    // R3 R4 R5 R6 R7 R11: vector table
    for (int i = 0; i < NV; i++) begin
      acc(VECS[i][45:22], VECS[i][21:6], VECS[i][5], VECS[i][4], 1'b0);
      chk("R3/R11 trig", trig_o, |VECS[i][3:0]);
      chk("R11 src", trig_src_o, VECS[i][3:0]);
    end

    // R5: fully masked compare in invert mode never fires
    wr(2'd2, 3'd7, 8'h00);
    acc(24'h003000, 16'hFFFF, 1'b0, 1'b1, 1'b0);
    chk("R5 full mask", trig_o, 0);

    // R8: tag mode, direction qualifier ignored
    wr(2'd3, 3'd0, 8'h25);
    acc(24'h004000, 16'h0, 1'b0, 1'b1, 1'b1);
    chk("R8 no trig at fetch", trig_o, 0);
    ex(24'h009999, 1'b0);
    chk("R8 other exec", trig_o, 0);
    ex(24'h004000, 1'b0);
    chk("R8 exec fires", trig_src_o, 4'b1000);
    ex(24'h004000, 1'b0);
    chk("R8 tag consumed", trig_o, 0);

    // R9: capacity of four
    for (int i = 0; i < 5; i++) acc(24'h004000, 16'h0, 1'b0, 1'b1, 1'b1);
    for (int i = 0; i < 5; i++) begin
      ex(24'h004000, 1'b0);
      chk("R9 capacity", trig_o, (i < 4) ? 1 : 0);
    end
    // R9: flush drops tags
    acc(24'h004000, 16'h0, 1'b0, 1'b1, 1'b1);
    ex(24'h004000, 1'b1);
    chk("R9 flush same cycle", trig_o, 0);
    ex(24'h004000, 1'b0);
    chk("R9 after flush", trig_o, 0);

    // R10: break without enable
    wr(2'd0, 3'd0, 8'h11);
    acc(24'h001000, 16'h1234, 1'b0, 1'b1, 1'b0);
    chk("R10 trig no enable", trig_o, 1);
    chk("R10 no brk", brk_o, 0);
    rd(2'd0, 3'd0, r); chk("R10 still armed", r, 8'h11);
    // R10: break with enable
    brk_en = 1'b1;
    acc(24'h001000, 16'h1234, 1'b0, 1'b1, 1'b0);
    chk("R10 brk", brk_o, 1);
    chk("R10 brk trig", trig_o, 1);
    rd(2'd0, 3'd0, r); chk("R10 disarmed", r, 8'h10);
    acc(24'h001000, 16'h1234, 1'b0, 1'b1, 1'b0);
    chk("R10 silent after disarm", trig_o, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule